// File: doc/BRIEF.md
# Indexed Pointer Address Generator

This block carries out the address-calculation step of an accumulator-oriented processor mode. It keeps two banks of eight 32-bit address-high registers, called base and scratchpad, and a file of eight 64-bit pointer registers. An instruction request names one bank entry through a bank-select bit and a 3-bit source index, and carries a 15-bit offset, a 3-bit destination index, the current operand type and the value of accumulator B.

The selected 32-bit register becomes the upper part of a 47-bit physical address and the offset becomes its lower 15 bits. The low 47 bits of accumulator B are added to that address as an index, and the sum wraps modulo 2^47. The result is zero-extended to 64 bits and written into the destination pointer register. When the operation completes, the block pulses a request to clear accumulator A. The operation is defined only for the integer types. For any other type code, nothing is written and an illegal-operation pulse is raised instead.

A separate write port loads the base and scratchpad registers. A combinational read port exposes any pointer register.

Top module: `ptr_index_agen`

## Requirements
- R1: `req_bank` = 0 selects the base bank and `req_bank` = 1 selects the scratchpad bank; `req_src` picks the entry inside that bank.
- R2: The effective address is the 47-bit value {selected register[31:0], `req_offset`[14:0]}, with the register in bits 46:15 and the offset in bits 14:0.
- R3: The stored pointer is (effective address + `acc_b`[46:0]) mod 2^47, and bits 63:47 of the pointer are zero. Bits 63:47 of `acc_b` have no effect.
- R4: Only the pointer register named by `req_dst` changes. The other seven keep their values.
- R5: A request is sampled on the clock edge where `req_valid` is high (edge N). The pointer read port still shows the old value after edge N and shows the new value after edge N+1.
- R6: For a legal request, `acc_a_clr` is high for exactly the one cycle between edges N+1 and N+2.
- R7: Type codes 0 to 3 are integer types and legal. For type codes 4 to 7, no pointer is written, `acc_a_clr` stays low, and `illegal_op` is high for exactly the cycle between edges N+1 and N+2.
- R8: Synchronous active-high reset clears all base, scratchpad and pointer registers to zero and drives `acc_a_clr` and `illegal_op` low.
- R9: When `cfg_wr_en` is high at a clock edge, `cfg_wr_data` is written into entry `cfg_wr_idx` of the bank chosen by `cfg_wr_bank` (0 = base, 1 = scratchpad). The other bank is untouched.
- R10: Requests may be issued on consecutive cycles. Each one completes in issue order, and a later request to the same destination overwrites an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Bank register write enable |
| cfg_wr_bank | input | 1 | Bank for the write: 0 base, 1 scratchpad |
| cfg_wr_idx | input | 3 | Bank entry to write |
| cfg_wr_data | input | 32 | Value to write |
| req_valid | input | 1 | One-cycle request strobe |
| req_bank | input | 1 | Source bank: 0 base, 1 scratchpad |
| req_src | input | 3 | Source entry index |
| req_offset | input | 15 | Low address bits from the instruction |
| req_dst | input | 3 | Destination pointer index |
| req_type | input | 3 | Current operand type code |
| acc_b | input | 64 | Accumulator B value (index) |
| ptr_rd_idx | input | 3 | Pointer read index |
| ptr_rd_data | output | 64 | Pointer register contents |
| acc_a_clr | output | 1 | One-cycle request to clear accumulator A |
| illegal_op | output | 1 | One-cycle illegal-type pulse |

## Verification
The hardest cases to reach are the 47-bit wrap and the masking of accumulator B's upper bits. Both need a bank register loaded with all ones or a specific pattern beforehand, because the address-high part can only be set through the configuration port. Directed sequences preload such values and then issue requests with an offset of all ones and a B of one, and with B carrying only bits 63:47. Back-to-back requests that collide on one destination are driven on consecutive cycles, so that the pipeline-stage write and the next capture overlap. Random requests with all eight type codes cover the legal and illegal paths.

// File: rtl/ipag_pkg.sv
package ipag_pkg;

    localparam int NUM_REGS = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int HI_W     = 32;
    localparam int OFS_W    = 15;
    localparam int PA_W     = HI_W + OFS_W;
    localparam int PTR_W    = 64;
    localparam int ACC_W    = 64;
    localparam int TYPE_W   = 3;
    localparam int PAD_W    = PTR_W - PA_W;

    typedef enum logic {
        BANK_BASE    = 1'b0,
        BANK_SCRATCH = 1'b1
    } bank_e;

    typedef struct packed {
        logic [HI_W-1:0]  hi_part;
        logic [OFS_W-1:0] offset;
    } eff_addr_t;

    typedef struct packed {
        logic             valid;
        logic             legal;
        logic [IDX_W-1:0] dst;
        logic [PA_W-1:0]  addr;
    } stage_t;

    function automatic logic [PA_W-1:0] build_ea(input logic [HI_W-1:0] hi,
                                                 input logic [OFS_W-1:0] ofs);
        eff_addr_t ea;
        ea.hi_part = hi;
        ea.offset  = ofs;
        return ea;
    endfunction

    function automatic logic [PA_W-1:0] index_sum(input logic [PA_W-1:0]  ea,
                                                  input logic [ACC_W-1:0] idx);
        return ea + idx[PA_W-1:0];
    endfunction

    function automatic logic [PTR_W-1:0] widen_ptr(input logic [PA_W-1:0] pa);
        return {{PAD_W{1'b0}}, pa};
    endfunction

    function automatic logic type_is_integer(input logic [TYPE_W-1:0] t);
        return (t[TYPE_W-1] == 1'b0);
    endfunction

endpackage

// File: rtl/ipag_regbank.sv
module ipag_regbank #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] entry_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= '0;
            end else if (wr_en && (wr_idx == AW'(g))) begin
                entry_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = entry_q[rd_idx];

endmodule

// File: rtl/ipag_agu.sv
module ipag_agu
    import ipag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [HI_W-1:0]   hi_value,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [IDX_W-1:0]  req_dst,
    input  logic [TYPE_W-1:0] req_type,
    input  logic [ACC_W-1:0]  acc_b,
    output stage_t            stage
);

    stage_t stage_d;
    logic [PA_W-1:0] ea;

    always_comb begin
        ea            = build_ea(hi_value, req_offset);
        stage_d.valid = req_valid;
        stage_d.legal = type_is_integer(req_type);
        stage_d.dst   = req_dst;
        stage_d.addr  = index_sum(ea, acc_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else begin
            stage <= stage_d;
        end
    end

endmodule

// File: rtl/ipag_ptr_file.sv
module ipag_ptr_file
    import ipag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  stage_t           stage,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PTR_W-1:0] rd_data,
    output logic             clr_pulse,
    output logic             ill_pulse
);

    logic [PTR_W-1:0] ptr_q [NUM_REGS];
    logic             commit;

    assign commit = stage.valid && stage.legal;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[g] <= '0;
            end else if (commit && (stage.dst == IDX_W'(g))) begin
                ptr_q[g] <= widen_ptr(stage.addr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_pulse <= 1'b0;
            ill_pulse <= 1'b0;
        end else begin
            clr_pulse <= commit;
            ill_pulse <= stage.valid && !stage.legal;
        end
    end

    assign rd_data = ptr_q[rd_idx];

endmodule

// File: rtl/ptr_index_agen.sv
module ptr_index_agen
    import ipag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_bank,
    input  logic [IDX_W-1:0]  cfg_wr_idx,
    input  logic [HI_W-1:0]   cfg_wr_data,
    input  logic              req_valid,
    input  logic              req_bank,
    input  logic [IDX_W-1:0]  req_src,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [IDX_W-1:0]  req_dst,
    input  logic [TYPE_W-1:0] req_type,
    input  logic [ACC_W-1:0]  acc_b,
    input  logic [IDX_W-1:0]  ptr_rd_idx,
    output logic [PTR_W-1:0]  ptr_rd_data,
    output logic              acc_a_clr,
    output logic              illegal_op
);

    localparam int NBANKS = 2;

    logic [HI_W-1:0] bank_rd [NBANKS];
    logic [HI_W-1:0] hi_sel;
    stage_t          stage;

    // R1 R9: one bank instance per select value
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        ipag_regbank #(
            .DEPTH(NUM_REGS),
            .WIDTH(HI_W)
        ) bank_i (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (cfg_wr_en && (cfg_wr_bank == 1'(b))),
            .wr_idx (cfg_wr_idx),
            .wr_data(cfg_wr_data),
            .rd_idx (req_src),
            .rd_data(bank_rd[b])
        );
    end

    always_comb begin
        hi_sel = (bank_e'(req_bank) == BANK_SCRATCH) ? bank_rd[1] : bank_rd[0];
    end

    ipag_agu agu_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .hi_value  (hi_sel),
        .req_offset(req_offset),
        .req_dst   (req_dst),
        .req_type  (req_type),
        .acc_b     (acc_b),
        .stage     (stage)
    );

    ipag_ptr_file ptr_i (
        .clk      (clk),
        .rst      (rst),
        .stage    (stage),
        .rd_idx   (ptr_rd_idx),
        .rd_data  (ptr_rd_data),
        .clr_pulse(acc_a_clr),
        .ill_pulse(illegal_op)
    );

endmodule

// File: rtl/ptr_index_agen_chk.sv
module ptr_index_agen_chk
    import ipag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [TYPE_W-1:0] req_type,
    input logic [IDX_W-1:0]  ptr_rd_idx,
    input logic [PTR_W-1:0]  ptr_rd_data,
    input logic              acc_a_clr,
    input logic              illegal_op
);

    a_r6_clear_follows_legal: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_type < 3'd4) |=> ##1 acc_a_clr);

    a_r7_illegal_follows_bad_type: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_type >= 3'd4) |=> ##1 (illegal_op && !acc_a_clr));

    a_r7_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(acc_a_clr && illegal_op));

    a_r6_clear_has_source: assert property (@(posedge clk) disable iff (rst)
        acc_a_clr |-> $past(req_valid, 2));

    a_r4_ptr_stable_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(req_valid, 2) && $stable(ptr_rd_idx)) |-> $stable(ptr_rd_data));

    a_r3_upper_bits_zero: assert property (@(posedge clk) disable iff (rst)
        ptr_rd_data[PTR_W-1:PA_W] == '0);

endmodule

bind ptr_index_agen ptr_index_agen_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_type   (req_type),
    .ptr_rd_idx (ptr_rd_idx),
    .ptr_rd_data(ptr_rd_data),
    .acc_a_clr  (acc_a_clr),
    .illegal_op (illegal_op)
);

// File: tb/ptr_index_agen_tb_top.sv
module ptr_index_agen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_bank = 1'b0;
    logic [2:0]  cfg_wr_idx = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_bank = 1'b0;
    logic [2:0]  req_src = '0;
    logic [14:0] req_offset = '0;
    logic [2:0]  req_dst = '0;
    logic [2:0]  req_type = '0;
    logic [63:0] acc_b = '0;
    logic [2:0]  ptr_rd_idx = '0;
    logic [63:0] ptr_rd_data;
    logic        acc_a_clr;
    logic        illegal_op;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] base_m [8];
    logic [31:0] scr_m  [8];
    logic [63:0] ptr_m  [8];

    always #2 clk = ~clk;

    ptr_index_agen dut_i (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_bank(cfg_wr_bank),
        .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .req_valid(req_valid), .req_bank(req_bank), .req_src(req_src),
        .req_offset(req_offset), .req_dst(req_dst), .req_type(req_type),
        .acc_b(acc_b), .ptr_rd_idx(ptr_rd_idx), .ptr_rd_data(ptr_rd_data),
        .acc_a_clr(acc_a_clr), .illegal_op(illegal_op)
    );

    function automatic logic [63:0] expect_ptr(input logic [31:0] hi,
                                               input logic [14:0] ofs,
                                               input logic [63:0] b);
        logic [46:0] s;
        s = {hi, ofs} + b[46:0];
        return {17'b0, s};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 8; i++) begin
            ptr_rd_idx = 3'(i);
            #1;
            chk(req, ptr_rd_data, ptr_m[i]);
        end
    endtask

    task automatic bank_write(input logic bank, input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_bank = bank; cfg_wr_idx = idx; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (bank) scr_m[idx] = d; else base_m[idx] = d;
    endtask

    task automatic issue(input logic bank, input logic [2:0] src, input logic [14:0] ofs,
                         input logic [2:0] dst, input logic [2:0] typ, input logic [63:0] b);
        logic [63:0] old, exp;
        logic legal;
        legal = (typ < 3'd4);
        @(negedge clk);
        req_valid = 1'b1; req_bank = bank; req_src = src; req_offset = ofs;
        req_dst = dst; req_type = typ; acc_b = b;
        old = ptr_m[dst];
        exp = legal ? expect_ptr(bank ? scr_m[src] : base_m[src], ofs, b) : old;
        @(negedge clk);
        req_valid = 1'b0;
        ptr_rd_idx = dst;
        #1;
        chk("R5 old value after edge N", ptr_rd_data, old);
        chk("R6 no early clear", {63'b0, acc_a_clr}, 64'd0);
        @(negedge clk);
        #1;
        chk("R3 R7 pointer after edge N+1", ptr_rd_data, exp);
        chk("R6 clear pulse", {63'b0, acc_a_clr}, {63'b0, legal});
        chk("R7 illegal pulse", {63'b0, illegal_op}, {63'b0, !legal});
        ptr_m[dst] = exp;
        @(negedge clk);
        #1;
        chk("R6 R7 pulses one cycle", {62'b0, acc_a_clr, illegal_op}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 8; i++) begin
            base_m[i] = '0; scr_m[i] = '0; ptr_m[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R8 reset state
        check_all("R8 reset pointers");
        chk("R8 reset pulses", {62'b0, acc_a_clr, illegal_op}, 64'd0);

        // R9 R1 bank load and select
        bank_write(1'b0, 3'd3, 32'hA5A5_0001);
        bank_write(1'b1, 3'd3, 32'h0F0F_0002);
        issue(1'b0, 3'd3, 15'd0, 3'd0, 3'd0, 64'd0);
        issue(1'b1, 3'd3, 15'd0, 3'd1, 3'd1, 64'd0);
        // R2 concatenation placement
        issue(1'b0, 3'd3, 15'h7FFF, 3'd2, 3'd2, 64'd0);
        // R3 wrap modulo 2^47
        bank_write(1'b1, 3'd7, 32'hFFFF_FFFF);
        issue(1'b1, 3'd7, 15'h7FFF, 3'd4, 3'd3, 64'd1);
        chk("R3 wrap to zero", ptr_m[4], 64'd0);
        // R3 upper B bits ignored
        issue(1'b0, 3'd3, 15'h1234, 3'd5, 3'd0, 64'hFFFF_8000_0000_0000);
        // R7 illegal types
        for (int t = 4; t < 8; t++) issue(1'b1, 3'd3, 15'h0055, 3'd6, 3'(t), 64'd9);
        // R4 others untouched
        check_all("R4 full scan");

        // R10 back-to-back with collision on dst 2
        begin
            logic [2:0]  dsts [4] = '{3'd2, 3'd7, 3'd2, 3'd3};
            logic [14:0] ofss [4] = '{15'd10, 15'd20, 15'd30, 15'd40};
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                req_valid = 1'b1; req_bank = 1'(k); req_src = 3'd3;
                req_offset = ofss[k]; req_dst = dsts[k]; req_type = 3'd2;
                acc_b = 64'(k * 100);
                ptr_m[dsts[k]] = expect_ptr(k[0] ? scr_m[3] : base_m[3], ofss[k], 64'(k * 100));
            end
            @(negedge clk);
            req_valid = 1'b0;
            @(negedge clk);
            check_all("R10 back-to-back order");
        end

        // random mix
        for (int n = 0; n < 40; n++)
            bank_write(1'($urandom), 3'($urandom), $urandom);
        for (int n = 0; n < 300; n++)
            issue(1'($urandom), 3'($urandom), 15'($urandom), 3'($urandom),
                  3'($urandom), {$urandom, $urandom});
        check_all("R4 final scan");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule